// File: doc/BRIEF.md
# DDR Burst Column Sequencer

This block produces the column addresses of a DDR SDRAM burst, two beats per clock, from one starting column. A start pulse captures the starting column together with the burst-length code and the ordering bit of the mode settings. On each following cycle the block presents the column of the even beat and of the odd beat of the current pair. It raises a flag on the final pair and then goes idle.

Only the low log2(BL) bits of the column wrap inside the aligned burst block; the upper bits are carried through unchanged. Two wrap orderings are offered. The sequential ordering adds the beat number to the start offset modulo the burst length. The interleaved ordering XORs the beat number into the start offset. A terminate input cuts a burst short. A new start pulse replaces a running burst at once, with no idle cycle between the two.

Top module: `burst_col_seq`

## Requirements
- R1: The length code `bl_code` selects the burst length: 3'b001 gives 2 beats, 3'b010 gives 4 beats and 3'b011 gives 8 beats. `pair_valid` is high for BL/2 consecutive cycles, and the first of them is the cycle after the start pulse is sampled.
- R2: The ordering input `interleave` picks the ordering: 0 is sequential and 1 is interleaved.
- R3: In sequential ordering, with S = start column mod BL, beat b has low bits (S + b) mod BL. For example, start 1 at BL4 gives 1,2,3,0.
- R4: In interleaved ordering, beat b has low bits S XOR b. For example, start 3 at BL8 gives 3,2,1,0,7,6,5,4.
- R5: Column bits at positions log2(BL) and above equal those of the start column on every beat of the burst.
- R6: In each valid cycle k (k counted from 0), `col_even` carries beat 2k and `col_odd` carries beat 2k+1.
- R7: A sampled `burst_stop` with no start in the same cycle drives `pair_valid` low in the next cycle.
- R8: `last_pair` is high only on the final pair of a burst. Without a new start, `pair_valid` is low in the cycle after it.
- R9: A start pulse sampled during a burst makes the next cycle carry pair 0 of the new burst. A start sampled together with a stop wins over the stop.
- R10: A reserved length code (any code other than 001, 010 or 011) runs a 2-beat burst. `len_err` is high from the cycle after such a start until the next accepted start.
- R11: After reset, `pair_valid`, `last_pair` and `len_err` are low.
- R12: Length, ordering and column inputs are sampled only with a start pulse. Changes to them during a burst do not affect its columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_start | input | 1 | Start pulse; captures the column and mode inputs |
| start_col | input | 9 | Starting column address |
| bl_code | input | 3 | Burst-length code |
| interleave | input | 1 | 0 = sequential, 1 = interleaved ordering |
| burst_stop | input | 1 | Terminates the running burst |
| pair_valid | output | 1 | A column pair is presented this cycle |
| col_even | output | 9 | Column of beat 2k |
| col_odd | output | 9 | Column of beat 2k+1 |
| last_pair | output | 1 | Final pair of the burst |
| len_err | output | 1 | Last accepted start used a reserved length code |

## Verification
The assertions check on every cycle the control rules of R5, R7, R8, R9 and R10:
- both columns of a pair stay in one aligned block;
- a stop empties the output next cycle;
- a last pair is followed by idle;
- a start yields a valid pair next cycle;
- a reserved-code burst is one pair long.

Only the bench's scenarios can show that the column values follow the sequential and interleaved formulas. The bench sweeps every start column, every length code and both orderings for this. The bench also covers the cases that need a sequence of stimulus: restarting mid-burst, stopping early, and changing the mode inputs mid-burst without effect.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    localparam int BL_CODE_W = 3;

endpackage

// File: rtl/bseq_len_decode.sv
module bseq_len_decode #(
    parameter int MAX_LG = 3,
    parameter int LG_W   = $clog2(MAX_LG + 1)
) (
    input  logic [burst_col_seq_pkg::BL_CODE_W-1:0] code,
    output logic [LG_W-1:0]                         lg,
    output logic                                    reserved
);
    localparam int CW = burst_col_seq_pkg::BL_CODE_W;

    always_comb begin
        lg       = LG_W'(1);
        reserved = 1'b1;
        for (int c = 1; c <= MAX_LG; c++) begin
            if (code == CW'(c)) begin
                lg       = LG_W'(c);
                reserved = 1'b0;
            end
        end
    end
endmodule

// File: rtl/bseq_lane_addr.sv
module bseq_lane_addr
    import burst_col_seq_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int MAX_LG = 3,
    parameter int LG_W   = $clog2(MAX_LG + 1)
) (
    input  logic [COL_W-1:0]  base,
    input  logic [LG_W-1:0]   lg,
    input  order_e            order,
    input  logic [MAX_LG-1:0] beat,
    output logic [COL_W-1:0]  col
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] beat_ext;
    logic [COL_W-1:0] off;

    always_comb begin
        mask     = (COL_W'(1) << lg) - COL_W'(1);
        beat_ext = COL_W'(beat);
        if (order == ORD_ILV) off = base ^ beat_ext;
        else                  off = base + beat_ext;
        col = (base & ~mask) | (off & mask);
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_col_seq_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int MAX_LG = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 burst_start,
    input  logic [COL_W-1:0]     start_col,
    input  logic [BL_CODE_W-1:0] bl_code,
    input  logic                 interleave,
    input  logic                 burst_stop,
    output logic                 pair_valid,
    output logic [COL_W-1:0]     col_even,
    output logic [COL_W-1:0]     col_odd,
    output logic                 last_pair,
    output logic                 len_err
);
    localparam int LG_W   = $clog2(MAX_LG + 1);
    localparam int PAIR_W = (MAX_LG > 1) ? MAX_LG - 1 : 1;
    localparam int LANES  = 2;

    typedef struct packed {
        logic              active;
        logic [PAIR_W-1:0] pidx;
        logic [COL_W-1:0]  base;
        logic [LG_W-1:0]   lg;
        order_e            order;
        logic              err;
    } seq_state_t;

    seq_state_t st_q, st_d;

    logic [LG_W-1:0]   dec_lg;
    logic              dec_res;
    logic [PAIR_W-1:0] pairs_m1;
    logic              at_last;
    logic [COL_W-1:0]  lane_col [LANES];

    bseq_len_decode #(.MAX_LG(MAX_LG), .LG_W(LG_W)) u_dec (
        .code     (bl_code),
        .lg       (dec_lg),
        .reserved (dec_res)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        bseq_lane_addr #(.COL_W(COL_W), .MAX_LG(MAX_LG), .LG_W(LG_W)) u_lane (
            .base  (st_q.base),
            .lg    (st_q.lg),
            .order (st_q.order),
            .beat  ({st_q.pidx, 1'(i)}),
            .col   (lane_col[i])
        );
    end

    always_comb begin
        pairs_m1 = PAIR_W'((32'd1 << (st_q.lg - LG_W'(1))) - 32'd1);
        at_last  = st_q.active && (st_q.pidx == pairs_m1);
        st_d     = st_q;
        if (burst_start) begin
            st_d.active = 1'b1;
            st_d.pidx   = '0;
            st_d.base   = start_col;
            st_d.lg     = dec_lg;
            st_d.order  = interleave ? ORD_ILV : ORD_SEQ;
            st_d.err    = dec_res;
        end else if (burst_stop) begin
            st_d.active = 1'b0;
            st_d.pidx   = '0;
        end else if (st_q.active) begin
            if (at_last) begin
                st_d.active = 1'b0;
                st_d.pidx   = '0;
            end else begin
                st_d.pidx = st_q.pidx + PAIR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, pidx: '0, base: '0, lg: LG_W'(1),
                      order: ORD_SEQ, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pair_valid = st_q.active;
    assign col_even   = lane_col[0];
    assign col_odd    = lane_col[1];
    assign last_pair  = at_last;
    assign len_err    = st_q.err;

    AST_PAIR_SAME_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> ((col_even >> st_q.lg) == (col_odd >> st_q.lg))); // R5

    AST_STOP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !burst_start) |=> !pair_valid); // R7

    AST_LAST_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (last_pair && !burst_start) |=> !pair_valid); // R8

    AST_START_GIVES_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> (pair_valid && st_q.pidx == '0)); // R9

    AST_RESERVED_ONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && len_err) |-> last_pair); // R10

endmodule

// File: tb/burst_col_seq_tb_top.sv
`timescale 1ns/1ps
module burst_col_seq_tb_top;
    localparam int COL_W = 9;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             burst_start;
    logic [COL_W-1:0] start_col;
    logic [2:0]       bl_code;
    logic             interleave;
    logic             burst_stop;
    logic             pair_valid;
    logic [COL_W-1:0] col_even;
    logic [COL_W-1:0] col_odd;
    logic             last_pair;
    logic             len_err;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 0;

    always #2.5 clk = ~clk;

    burst_col_seq dut_i (
        .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .start_col(start_col),
        .bl_code(bl_code), .interleave(interleave), .burst_stop(burst_stop),
        .pair_valid(pair_valid), .col_even(col_even), .col_odd(col_odd),
        .last_pair(last_pair), .len_err(len_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int len_of(input int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 2;
        endcase
    endfunction

    function automatic int exp_col(input int col, input int bl, input int ilv, input int b);
        int s, low;
        s = col % bl;
        if (ilv != 0) low = s ^ b;
        else          low = (s + b) % bl;
        return (col / bl) * bl + low;
    endfunction

    // Called at a negedge; returns at a negedge with the block idle and checked.
    task automatic run_burst(input int code, input int ilv, input int col, input bit scramble);
        int bl, np, ea, eb;
        bit eerr;
        bl   = len_of(code);
        np   = bl / 2;
        eerr = !(code >= 1 && code <= 3);
        burst_start = 1'b1;
        bl_code     = 3'(code);
        interleave  = ilv[0];
        start_col   = COL_W'(col);
        @(negedge clk);
        burst_start = 1'b0;
        if (scramble) begin
            bl_code    = 3'b000;
            interleave = ~interleave;
            start_col  = ~start_col;
        end
        for (int p = 0; p < np; p++) begin
            ea = exp_col(col, bl, ilv, 2 * p);
            eb = exp_col(col, bl, ilv, 2 * p + 1);
            check(pair_valid == 1'b1, "R1 valid", int'(pair_valid), 1);
            if (ilv != 0) begin
                check(int'(col_even) == ea, "R4 even", int'(col_even), ea);
                check(int'(col_odd)  == eb, "R4 odd",  int'(col_odd),  eb);
            end else begin
                check(int'(col_even) == ea, "R3 even", int'(col_even), ea);
                check(int'(col_odd)  == eb, "R3 odd",  int'(col_odd),  eb);
            end
            check((int'(col_even) / bl) == (col / bl), "R5 upper bits", int'(col_even) / bl, col / bl);
            check(last_pair == (p == np - 1), "R8 last flag", int'(last_pair), int'(p == np - 1));
            check(len_err == eerr, "R10 err flag", int'(len_err), int'(eerr));
            @(negedge clk);
        end
        check(pair_valid == 1'b0, "R8 idle after last", int'(pair_valid), 0);
    endtask

    initial begin
        rst_n = 1'b0; burst_start = 1'b0; start_col = '0; bl_code = 3'b011;
        interleave = 1'b0; burst_stop = 1'b0;
        repeat (3) @(negedge clk);
        check(pair_valid == 1'b0, "R11 valid", int'(pair_valid), 0);
        check(last_pair == 1'b0,  "R11 last",  int'(last_pair), 0);
        check(len_err == 1'b0,    "R11 err",   int'(len_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R5 R6 R10: sweep codes, orderings, start columns
        for (int code = 0; code < 8; code++)
            for (int ilv = 0; ilv < 2; ilv++)
                for (int col = 0; col < 512; col++)
                    run_burst(code, ilv, col, 1'b0);

        // R12: mode inputs changed mid-burst
        run_burst(3, 0, 5, 1'b1);
        run_burst(3, 1, 403, 1'b1);
        run_burst(2, 0, 258, 1'b1);

        // R7: stop after first pair
        burst_start = 1'b1; bl_code = 3'b011; interleave = 1'b1; start_col = 9'd10;
        @(negedge clk);
        burst_start = 1'b0; burst_stop = 1'b1;
        check(pair_valid == 1'b1, "R7 first pair", int'(pair_valid), 1);
        check(int'(col_even) == exp_col(10, 8, 1, 0), "R7 first col", int'(col_even), exp_col(10, 8, 1, 0));
        @(negedge clk);
        burst_stop = 1'b0;
        check(pair_valid == 1'b0, "R7 stopped", int'(pair_valid), 0);
        @(negedge clk);
        check(pair_valid == 1'b0, "R7 stays idle", int'(pair_valid), 0);

        // R9: restart mid-burst, start wins over stop
        burst_start = 1'b1; bl_code = 3'b011; interleave = 1'b0; start_col = 9'd3;
        @(negedge clk);
        burst_start = 1'b0;
        @(negedge clk);
        check(int'(col_even) == 5, "R9 old burst pair1", int'(col_even), 5);
        burst_start = 1'b1; burst_stop = 1'b1; bl_code = 3'b010; interleave = 1'b1; start_col = 9'h1F6;
        @(negedge clk);
        burst_start = 1'b0; burst_stop = 1'b0;
        check(pair_valid == 1'b1, "R9 restart valid", int'(pair_valid), 1);
        check(int'(col_even) == 9'h1F6, "R9 restart even", int'(col_even), 9'h1F6);
        check(int'(col_odd) == 9'h1F7, "R9 restart odd", int'(col_odd), 9'h1F7);
        check(last_pair == 1'b0, "R9 restart not last", int'(last_pair), 0);
        @(negedge clk);
        check(int'(col_even) == 9'h1F4, "R9 second even", int'(col_even), 9'h1F4);
        check(int'(col_odd) == 9'h1F5, "R9 second odd", int'(col_odd), 9'h1F5);
        check(last_pair == 1'b1, "R9 second last", int'(last_pair), 1);
        @(negedge clk);
        check(pair_valid == 1'b0, "R8 idle after restart burst", int'(pair_valid), 0);

        // R10: reserved code raises error, cleared by next valid start
        run_burst(7, 0, 100, 1'b0);
        check(len_err == 1'b1, "R10 err held", int'(len_err), 1);
        run_burst(1, 0, 100, 1'b0);
        check(len_err == 1'b0, "R10 err cleared", int'(len_err), 0);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule